// File: doc/BRIEF.md
# Tamper Failure-State Supervisor

This block watches a battery-backed security domain and keeps its state in two independent flags. One flag marks the domain as not valid, which is the state after battery power returns. The other marks a security violation, raised when any enabled tamper or counter-overflow event arrives. Each event source has its own enable bit. When an enabled event fires, the block records which source caused it. While the violation flag is set, the block asserts a freeze output that halts the domain's counters. It can also raise an interrupt.

Software reaches the block through a simple register port with a write strobe and a combinational read. It can set configuration locks, but never clear them. A soft lock is removed by a system power-on reset. A hard lock is removed only by a battery reset. The domain can only be recovered after a system reset has moved it into the combined not-valid plus violation state. Software then clears the cause bits, then the violation flag, and the not-valid flag last. A failure hard lock blocks this recovery entirely, leaving a battery reset as the only way out.

Top module: `tamper_supervisor`

## Requirements
- R1: While `bat_rst_n` is low, and after it is released, the status register reads 0x0000_0002. Only bit 1 (not-valid) is set. The control, interrupt-enable and source-enable registers read 0, and `freeze` and `irq` are low.
- R2: Event input `i` is enabled by source-enable bit `i`. When an enabled event pulses, the next cycle shows its cause bit and status bit 0 (violation) set. Inputs 0 to 7 map to status bits 16 to 23 (voltage, clock, temperature, secure controller, external boot, external A, external B, wire mesh). Input 8 (time overflow) maps to status bit 2, and input 9 (monotonic overflow) maps to status bit 3.
- R3: A pulse on an event whose source-enable bit is 0 changes no status bit.
- R4: Writes to the source-enable register are ignored while control bit 29 (soft lock) or control bit 30 (hard lock) is set. Writing 1 to control bits 16, 29 or 30 sets them, and no write clears them.
- R5: Writing 1 to a cause bit in the status register clears it only while not-valid is set and control bit 16 (failure hard lock) is clear. An enabled event in the same cycle keeps the bit set.
- R6: Writing 1 to status bit 0 clears the violation flag only when three conditions hold: not-valid is set, the failure hard lock is clear, and no cause bit is set before that write.
- R7: A one-cycle `sys_por` pulse clears control bit 29 and the interrupt-enable register. If the violation flag is set, the pulse also sets not-valid. Control bits 16 and 30 are kept. Writes in the same cycle are ignored.
- R8: Writing 1 to status bit 1 clears not-valid only while the violation flag is clear.
- R9: `freeze` is high exactly when the violation flag is set.
- R10: `irq` is high exactly when the violation flag and interrupt-enable bit 0 are both set.
- R11: The registers sit at these addresses: control at 0x0, status at 0x4, interrupt enable at 0x8 and source enable at 0xC. `rd_data` shows the register at `rd_addr` in the same cycle, and a write is visible after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bat_rst_n | input | 1 | Battery power-on reset, asynchronous, active low |
| sys_por | input | 1 | System power-on reset pulse, synchronous, active high |
| evt_pulse | input | N_EVT | One-cycle event pulses, one per tamper or overflow source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data for `rd_addr` |
| freeze | output | 1 | Counter freeze, high while in violation |
| irq | output | 1 | Security-violation interrupt |

## Verification
The assertions take three things for granted about the inputs. `sys_por` lasts one cycle and is synchronous to `clk`. `bat_rst_n` is released away from a clock edge. Event pulses are one-cycle, synchronous strobes. The bench drives every input on the falling edge, raises `sys_por` for exactly one cycle, and never issues a write in the same cycle as `sys_por`. As a result, the lock and ordering properties only ever see writes that the block is meant to judge.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
   // status bit positions
   localparam int ST_VIOL    = 0;
   localparam int ST_NVAL    = 1;
   // control bit positions
   localparam int CT_FAIL_HL = 16;
   localparam int CT_CFG_SL  = 29;
   localparam int CT_CFG_HL  = 30;
   // register addresses
   localparam int A_CTRL     = 0;
   localparam int A_STAT     = 4;
   localparam int A_IRQEN    = 8;
   localparam int A_TCFG     = 12;
   localparam int EVT_MAX    = 10;

   typedef enum logic [3:0] {
      EV_VOLT, EV_CLK, EV_TEMP, EV_SECCTL, EV_XBOOT,
      EV_XA, EV_XB, EV_MESH, EV_TOVF, EV_MOVF
   } evt_e;

   // status position of the cause bit for event input i
   function automatic int cause_bit(input int i);
      if (i < int'(EV_TOVF)) return 16 + i;
      else                   return i - 6;
   endfunction
endpackage

// File: rtl/tmp_cause_bank.sv
module tmp_cause_bank #(
   parameter int N_EVT = 10
) (
   input  logic             clk,
   input  logic             bat_rst_n,
   input  logic [N_EVT-1:0] evt,
   input  logic [N_EVT-1:0] en,
   input  logic [N_EVT-1:0] clr,
   output logic [N_EVT-1:0] cause,
   output logic             hit
);
   logic [N_EVT-1:0] arm;
   assign arm = evt & en;
   assign hit = |arm;

   for (genvar g = 0; g < N_EVT; g++) begin : g_cause
      always_ff @(posedge clk or negedge bat_rst_n) begin
         if (!bat_rst_n)   cause[g] <= 1'b0;
         else if (arm[g])  cause[g] <= 1'b1;
         else if (clr[g])  cause[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/tmp_cfg_regs.sv
module tmp_cfg_regs #(
   parameter int N_EVT = 10
) (
   input  logic             clk,
   input  logic             bat_rst_n,
   input  logic             sys_por,
   input  logic             ctrl_we,
   input  logic             tcfg_we,
   input  logic             ie_we,
   input  logic             set_fail_hl,
   input  logic             set_cfg_sl,
   input  logic             set_cfg_hl,
   input  logic [N_EVT-1:0] tcfg_wdata,
   input  logic             ie_wdata,
   output logic             fail_hl,
   output logic             cfg_sl,
   output logic             cfg_hl,
   output logic [N_EVT-1:0] tcfg,
   output logic             irq_en
);
   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n) begin
         fail_hl <= 1'b0;
         cfg_hl  <= 1'b0;
      end else if (ctrl_we) begin
         fail_hl <= fail_hl | set_fail_hl;
         cfg_hl  <= cfg_hl  | set_cfg_hl;
      end
   end

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)   cfg_sl <= 1'b0;
      else if (sys_por) cfg_sl <= 1'b0;
      else if (ctrl_we) cfg_sl <= cfg_sl | set_cfg_sl;
   end

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)                       tcfg <= '0;
      else if (tcfg_we && !cfg_sl && !cfg_hl) tcfg <= tcfg_wdata;
   end

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)   irq_en <= 1'b0;
      else if (sys_por) irq_en <= 1'b0;
      else if (ie_we)   irq_en <= ie_wdata;
   end
endmodule

// File: rtl/tmp_state_flags.sv
module tmp_state_flags (
   input  logic clk,
   input  logic bat_rst_n,
   input  logic sys_por,
   input  logic hit,
   input  logic any_cause,
   input  logic fail_hl,
   input  logic clr_viol,
   input  logic clr_nval,
   output logic viol,
   output logic nval
);
   logic viol_ok;
   assign viol_ok = clr_viol && nval && !fail_hl && !any_cause;

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)   viol <= 1'b0;
      else if (hit)     viol <= 1'b1;
      else if (viol_ok) viol <= 1'b0;
   end

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)               nval <= 1'b1;
      else if (sys_por && viol)     nval <= 1'b1;
      else if (clr_nval && !viol)   nval <= 1'b0;
   end
endmodule

// File: rtl/tamper_supervisor.sv
module tamper_supervisor #(
   parameter int N_EVT  = 10,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              bat_rst_n,
   input  logic              sys_por,
   input  logic [N_EVT-1:0]  evt_pulse,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              freeze,
   output logic              irq
);
   import tamper_pkg::*;

   if (N_EVT < 1 || N_EVT > EVT_MAX) begin : g_bad_evt
      $error("N_EVT out of range");
   end
   if (DATA_W < CT_CFG_HL + 1) begin : g_bad_data
      $error("DATA_W too narrow for control bits");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too narrow for register map");
   end

   logic             we_ok, ctrl_we, stat_we, ie_we, tcfg_we;
   logic             fail_hl, cfg_sl, cfg_hl, irq_en, viol, nval, hit, any_cause;
   logic [N_EVT-1:0] tcfg, cause, clr, wsel;
   logic [DATA_W-1:0] ctrl_word, stat_word;

   assign we_ok   = wr_en && !sys_por;
   assign ctrl_we = we_ok && (wr_addr == ADDR_W'(A_CTRL));
   assign stat_we = we_ok && (wr_addr == ADDR_W'(A_STAT));
   assign ie_we   = we_ok && (wr_addr == ADDR_W'(A_IRQEN));
   assign tcfg_we = we_ok && (wr_addr == ADDR_W'(A_TCFG));

   for (genvar g = 0; g < N_EVT; g++) begin : g_wsel
      assign wsel[g] = wr_data[cause_bit(g)];
   end
   assign clr       = (stat_we && nval && !fail_hl) ? wsel : '0;
   assign any_cause = |cause;

   tmp_cfg_regs #(.N_EVT(N_EVT)) u_cfg (
      .clk(clk), .bat_rst_n(bat_rst_n), .sys_por(sys_por),
      .ctrl_we(ctrl_we), .tcfg_we(tcfg_we), .ie_we(ie_we),
      .set_fail_hl(wr_data[CT_FAIL_HL]), .set_cfg_sl(wr_data[CT_CFG_SL]),
      .set_cfg_hl(wr_data[CT_CFG_HL]), .tcfg_wdata(wr_data[N_EVT-1:0]),
      .ie_wdata(wr_data[0]),
      .fail_hl(fail_hl), .cfg_sl(cfg_sl), .cfg_hl(cfg_hl),
      .tcfg(tcfg), .irq_en(irq_en)
   );

   tmp_cause_bank #(.N_EVT(N_EVT)) u_bank (
      .clk(clk), .bat_rst_n(bat_rst_n), .evt(evt_pulse), .en(tcfg),
      .clr(clr), .cause(cause), .hit(hit)
   );

   tmp_state_flags u_flags (
      .clk(clk), .bat_rst_n(bat_rst_n), .sys_por(sys_por), .hit(hit),
      .any_cause(any_cause), .fail_hl(fail_hl),
      .clr_viol(stat_we && wr_data[ST_VIOL]),
      .clr_nval(stat_we && wr_data[ST_NVAL]),
      .viol(viol), .nval(nval)
   );

   always_comb begin
      stat_word = '0;
      stat_word[ST_VIOL] = viol;
      stat_word[ST_NVAL] = nval;
      for (int i = 0; i < N_EVT; i++) stat_word[cause_bit(i)] = cause[i];
      ctrl_word = '0;
      ctrl_word[CT_FAIL_HL] = fail_hl;
      ctrl_word[CT_CFG_SL]  = cfg_sl;
      ctrl_word[CT_CFG_HL]  = cfg_hl;
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(A_CTRL))       rd_data = ctrl_word;
      else if (rd_addr == ADDR_W'(A_STAT))  rd_data = stat_word;
      else if (rd_addr == ADDR_W'(A_IRQEN)) rd_data[0] = irq_en;
      else if (rd_addr == ADDR_W'(A_TCFG))  rd_data[N_EVT-1:0] = tcfg;
   end

   assign freeze = viol;
   assign irq    = viol && irq_en;
endmodule

// File: rtl/tamper_supervisor_chk.sv
module tamper_supervisor_chk #(
   parameter int N_EVT = 10
) (
   input logic             clk,
   input logic             bat_rst_n,
   input logic             sys_por,
   input logic [N_EVT-1:0] evt_pulse,
   input logic             freeze,
   input logic             irq,
   input logic             nval,
   input logic             any_cause,
   input logic             fail_hl,
   input logic             cfg_sl,
   input logic             cfg_hl,
   input logic [N_EVT-1:0] tcfg
);
   AST_VIOL_FROM_EVENT: assert property (@(posedge clk) disable iff (!bat_rst_n)
      $rose(freeze) |-> $past(|evt_pulse)); // R2
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (cfg_sl || cfg_hl) |=> $stable(tcfg)); // R4
   AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!bat_rst_n)
      cfg_hl |=> cfg_hl); // R4
   AST_VIOL_CLEAR_GUARD: assert property (@(posedge clk) disable iff (!bat_rst_n)
      $fell(freeze) |-> ($past(nval) && !$past(any_cause) && !$past(fail_hl))); // R6
   AST_SOFT_DROP: assert property (@(posedge clk) disable iff (!bat_rst_n)
      sys_por |=> !cfg_sl); // R7
   AST_POR_NVAL: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (sys_por && freeze) |=> nval); // R7
   AST_NVAL_ORDER: assert property (@(posedge clk) disable iff (!bat_rst_n)
      $fell(nval) |-> !$past(freeze)); // R8
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!bat_rst_n)
      irq |-> freeze); // R10
   AST_FAIL_LOCK_HOLD: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (fail_hl && freeze) |=> freeze); // R6
endmodule

bind tamper_supervisor tamper_supervisor_chk #(.N_EVT(N_EVT)) u_chk (
   .clk(clk), .bat_rst_n(bat_rst_n), .sys_por(sys_por), .evt_pulse(evt_pulse),
   .freeze(freeze), .irq(irq), .nval(nval), .any_cause(any_cause),
   .fail_hl(fail_hl), .cfg_sl(cfg_sl), .cfg_hl(cfg_hl), .tcfg(tcfg)
);

// File: tb/sim_tamper_supervisor.sv
`timescale 1ns/1ps
module sim_tamper_supervisor;
   localparam int NE = 10;
   logic          clk = 1'b0;
   logic          bat_rst_n = 1'b0;
   logic          sys_por = 1'b0;
   logic [NE-1:0] evt_pulse = '0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [3:0]    rd_addr = 4'h4;
   logic [31:0]   rd_data;
   logic          freeze, irq;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tamper_supervisor u0 (.*);

   // behavioural reference state
   bit m_viol, m_nval, m_fhl, m_sl, m_hl, m_ie;
   bit [NE-1:0] m_cause, m_tcfg;

   function automatic int cpos(int i);
      return (i < 8) ? 16 + i : i - 6;
   endfunction

   function automatic logic [31:0] m_read(logic [3:0] a);
      logic [31:0] r = 0;
      case (a)
         4'h0: begin r[16] = m_fhl; r[29] = m_sl; r[30] = m_hl; end
         4'h4: begin
            r[0] = m_viol; r[1] = m_nval;
            for (int i = 0; i < NE; i++) r[cpos(i)] = m_cause[i];
         end
         4'h8: r[0] = m_ie;
         4'hC: r[NE-1:0] = m_tcfg;
         default: r = 0;
      endcase
      return r;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      bit [NE-1:0] hit_v, cl;
      bit wv, n_v, n_n, n_sl, n_ie;
      cyc++;
      if (!bat_rst_n) begin
         m_viol = 0; m_nval = 1; m_fhl = 0; m_sl = 0; m_hl = 0; m_ie = 0;
         m_cause = 0; m_tcfg = 0;
      end else begin
         hit_v = evt_pulse & m_tcfg;
         wv = wr_en && !sys_por;
         n_v = m_viol; n_n = m_nval; n_sl = m_sl; n_ie = m_ie;
         cl = 0;
         if (wv && wr_addr == 4'h4) begin
            if (m_nval && !m_fhl)
               for (int i = 0; i < NE; i++) cl[i] = wr_data[cpos(i)];
            if (wr_data[0] && m_nval && !m_fhl && m_cause == 0) n_v = 0;
            if (wr_data[1] && !m_viol) n_n = 0;
         end
         if (hit_v != 0) n_v = 1;
         if (sys_por) begin
            n_sl = 0; n_ie = 0;
            if (m_viol) n_n = 1;
         end
         if (wv && wr_addr == 4'h0) begin
            m_fhl |= wr_data[16]; m_hl |= wr_data[30]; n_sl = m_sl | wr_data[29];
         end
         if (wv && wr_addr == 4'hC && !m_sl && !m_hl) m_tcfg = wr_data[NE-1:0];
         if (wv && wr_addr == 4'h8) n_ie = wr_data[0];
         m_cause = (m_cause & ~cl) | hit_v;
         m_viol = n_v; m_nval = n_n; m_sl = n_sl; m_ie = n_ie;
      end
      #1;
      check("R9 freeze", {31'b0, freeze}, {31'b0, m_viol});
      check("R10 irq", {31'b0, irq}, {31'b0, m_viol & m_ie});
      check("R11 rd_data", rd_data, m_read(rd_addr));
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0; wr_data = 0;
   endtask

   task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
      rd_addr = a; #0.5;
      check(tag, rd_data, exp);
   endtask

   task automatic fire(logic [NE-1:0] m);
      @(negedge clk); evt_pulse = m;
      @(negedge clk); evt_pulse = 0;
   endtask

   task automatic por_pulse();
      @(negedge clk); sys_por = 1;
      @(negedge clk); sys_por = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      wait (cyc > 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rd_chk("R1 status at reset", 4'h4, 32'h2);
      bat_rst_n = 1;
      @(negedge clk);
      rd_chk("R1 status", 4'h4, 32'h2);
      rd_chk("R1 ctrl", 4'h0, 32'h0);
      rd_chk("R1 tcfg", 4'hC, 32'h0);
      check("R1 freeze", {31'b0, freeze}, 32'h0);

      fire(10'h001);
      rd_chk("R3 disabled event", 4'h4, 32'h2);
      wr(4'h4, 32'h2);
      rd_chk("R8 nval clear", 4'h4, 32'h0);
      wr(4'hC, 32'h3FF);
      rd_chk("R11 tcfg", 4'hC, 32'h3FF);
      wr(4'h8, 32'h1);
      fire(10'h004);
      rd_chk("R2 temp cause", 4'h4, 32'h0004_0001);
      check("R9 freeze high", {31'b0, freeze}, 32'h1);
      check("R10 irq high", {31'b0, irq}, 32'h1);
      wr(4'h4, 32'h0004_0001);
      rd_chk("R5 R6 clear without nval", 4'h4, 32'h0004_0001);

      wr(4'h0, 32'h2000_0000);
      rd_chk("R4 soft lock set", 4'h0, 32'h2000_0000);
      wr(4'hC, 32'h0);
      rd_chk("R4 tcfg locked", 4'hC, 32'h3FF);
      wr(4'h0, 32'h0);
      rd_chk("R4 lock not clearable", 4'h0, 32'h2000_0000);

      por_pulse();
      rd_chk("R7 status after por", 4'h4, 32'h0004_0003);
      rd_chk("R7 soft lock dropped", 4'h0, 32'h0);
      rd_chk("R7 irq enable dropped", 4'h8, 32'h0);
      check("R10 irq masked", {31'b0, irq}, 32'h0);

      wr(4'hC, 32'h0);
      rd_chk("R4 tcfg unlocked", 4'hC, 32'h0);
      wr(4'h4, 32'h1);
      rd_chk("R6 cause blocks clear", 4'h4, 32'h0004_0003);
      wr(4'h4, 32'h2);
      rd_chk("R8 nval held by viol", 4'h4, 32'h0004_0003);
      wr(4'h4, 32'h0004_0000);
      rd_chk("R5 cause cleared", 4'h4, 32'h3);
      wr(4'h4, 32'h1);
      rd_chk("R6 viol cleared", 4'h4, 32'h2);
      check("R9 freeze low", {31'b0, freeze}, 32'h0);
      wr(4'h4, 32'h2);
      rd_chk("R8 valid", 4'h4, 32'h0);

      wr(4'hC, 32'h3FF);
      for (int i = 0; i < NE; i++) begin
         logic [31:0] e;
         e = 32'h1 | (32'h1 << cpos(i));
         fire(NE'(1) << i);
         rd_chk($sformatf("R2 map event %0d", i), 4'h4, e);
         por_pulse();
         wr(4'h4, 32'h1 << cpos(i));
         wr(4'h4, 32'h1);
         wr(4'h4, 32'h2);
         rd_chk($sformatf("R2 recovered %0d", i), 4'h4, 32'h0);
      end

      wr(4'hC, 32'h100);
      fire(10'h100);
      rd_chk("R2 time overflow", 4'h4, 32'h5);
      wr(4'h0, 32'h4001_0000);
      por_pulse();
      rd_chk("R7 nval after por", 4'h4, 32'h7);
      rd_chk("R7 hard locks kept", 4'h0, 32'h4001_0000);
      wr(4'h4, 32'h4);
      rd_chk("R5 fail lock blocks cause", 4'h4, 32'h7);
      wr(4'h4, 32'h1);
      rd_chk("R6 fail lock blocks viol", 4'h4, 32'h7);
      wr(4'hC, 32'h0);
      rd_chk("R4 hard lock", 4'hC, 32'h100);

      @(negedge clk); bat_rst_n = 0;
      @(negedge clk);
      rd_chk("R1 battery status", 4'h4, 32'h2);
      rd_chk("R1 battery ctrl", 4'h0, 32'h0);
      bat_rst_n = 1;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule